// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block holds two one-word mailboxes that let two ports with unrelated clocks exchange single words outside the FIFO datapath. Mailbox 1 is loaded from port A and emptied from port B. Mailbox 2 is loaded from port B and emptied from port A. A word is posted by a write strobe with the port's mailbox select high. It is taken by a read strobe with the select high.

Each mailbox has an active-low "mail waiting" flag. The writer sees its own copy of the flag. That copy goes low on the posting edge and blocks further posts until the reader has taken the word. The reader sees a copy that goes low once the post event has crossed into its own clock domain. A take returns both copies high, again after a crossing delay on the writer side. Set and clear events cross as toggles through synchronizers, so each flag may lag the far side by a couple of its own clock cycles.

On each port the mailbox select also steers the data output. With the select high, the output shows the mailbox the port reads. With the select low, it shows the FIFO output word supplied from outside. A reset input for each mailbox stands in for a master or partial reset of the FIFO it travels with. The word width equals the port B bus width, `DATA_W`.

Top module: `mailbox_pair`

## Requirements
- R1: A port A clock edge with `a_wr_i` and `a_mbsel_i` high, while `a_mb1_full_no` is high, stores `a_wdata_i` in mailbox 1. After that edge, `a_mb1_full_no` reads low.
- R2: A post to a mailbox while the writer-side flag of that mailbox is low is ignored. The stored word stays as it was, and it is the word later delivered.
- R3: After a post to mailbox 1, `b_mb1_full_no` stays high after the first port B edge. It reads low after the second port B edge. A take then delivers the posted word on `b_dout_o`.
- R4: A port B edge with `b_rd_i` and `b_mbsel_i` high, while `b_mb1_full_no` is low, takes the word. After that edge, `b_mb1_full_no` reads high. `a_mb1_full_no` still reads low after the first port A edge and reads high after the second.
- R5: A read strobe with the select low has no effect on the flags. The same holds for a read strobe on an empty mailbox and for a write strobe with the select low. A later post and take still work normally.
- R6: Mailbox 2 behaves like mailbox 1 with the ports swapped. It is posted by `b_wr_i` and `b_mbsel_i`, taken by `a_rd_i` and `a_mbsel_i`, and flagged on `b_mb2_full_no` (writer side) and `a_mb2_full_no` (reader side). It has the same one-edge and two-edge timing.
- R7: With the port select high, the port data output shows the mailbox that port reads. With the select low, it shows that port's FIFO input word. The output follows combinationally.
- R8: `rst_ni` low, or the mailbox's own reset (`mb1_rst_ni`, `mb2_rst_ni`) low, asynchronously sets both flags of that mailbox high and clears its word to zero. A reset of one mailbox leaves the other untouched.
- R9: The stored word stays stable from its post until the take that clears the flag, whatever happens on the writer's data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock, unrelated to port A clock |
| rst_ni | input | 1 | Global asynchronous reset, active low |
| mb1_rst_ni | input | 1 | Reset of mailbox 1 (its FIFO's master or partial reset), active low |
| mb2_rst_ni | input | 1 | Reset of mailbox 2, active low |
| a_wr_i | input | 1 | Port A write strobe |
| a_rd_i | input | 1 | Port A read strobe |
| a_mbsel_i | input | 1 | Port A mailbox select |
| a_wdata_i | input | DATA_W | Port A write word |
| a_fifo_i | input | DATA_W | Port A FIFO output word |
| a_dout_o | output | DATA_W | Port A data output |
| a_mb1_full_no | output | 1 | Mailbox 1 flag, port A view, low = mail waiting |
| a_mb2_full_no | output | 1 | Mailbox 2 flag, port A view |
| b_wr_i | input | 1 | Port B write strobe |
| b_rd_i | input | 1 | Port B read strobe |
| b_mbsel_i | input | 1 | Port B mailbox select |
| b_wdata_i | input | DATA_W | Port B write word |
| b_fifo_i | input | DATA_W | Port B FIFO output word |
| b_dout_o | output | DATA_W | Port B data output |
| b_mb1_full_no | output | 1 | Mailbox 1 flag, port B view |
| b_mb2_full_no | output | 1 | Mailbox 2 flag, port B view |

## Verification
Four results have fixed due points:
- The writer's flag is due right after the posting edge.
- The reader's flag is due after exactly the second reader edge that follows the post.
- The writer's flag is released after exactly the second writer edge that follows the take.
- The data outputs follow the select with no clock at all.

The bench records the far clock's edge counter at each posting or taking edge. It samples on the falling edge after the counted edges, and checks both the edge before the due one and the due one. The two clocks are given odd and even edge times so that they never coincide. Where the near-side and far-side windows overlap, they are checked in parallel branches.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_CH          = 2;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned CH_A2B          = 0;
  localparam int unsigned CH_B2A          = 1;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= 1'b0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_w_i,
  input  logic              clk_r_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_w_no,
  output logic              full_r_no
);
  logic              wr_tgl_q, rd_tgl_q;
  logic              ack_s, post_s;
  logic              full_w, full_r;
  logic [DATA_W-1:0] data_q;

  // writer domain
  assign full_w = wr_tgl_q ^ ack_s;

  always_ff @(posedge clk_w_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tgl_q <= 1'b0;
      data_q   <= '0;
    end else if (wr_i && !full_w) begin
      wr_tgl_q <= ~wr_tgl_q;
      data_q   <= wdata_i;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_w_i),
    .rst_ni(rst_ni),
    .d_i   (rd_tgl_q),
    .q_o   (ack_s)
  );

  // reader domain
  mbx_sync #(.STAGES(SYNC_STAGES)) u_post_sync (
    .clk_i (clk_r_i),
    .rst_ni(rst_ni),
    .d_i   (wr_tgl_q),
    .q_o   (post_s)
  );

  assign full_r = post_s ^ rd_tgl_q;

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)               rd_tgl_q <= 1'b0;
    else if (rd_i && full_r)   rd_tgl_q <= ~rd_tgl_q;
  end

  // data_q is frozen while the post is outstanding, so reader may use it directly
  assign rdata_o   = data_q;
  assign full_w_no = ~full_w;
  assign full_r_no = ~full_r;

  a_r1_post_sets_flag: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    (wr_i && !full_w) |=> full_w);

  a_r2_post_blocked: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    (wr_i && full_w) |=> $stable(wr_tgl_q));

  a_r9_data_held: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    full_w |=> $stable(data_q));

  a_r4_take_clears: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_i && full_r) |=> !full_r);

  a_r5_empty_take_ignored: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_i && !full_r) |=> $stable(rd_tgl_q));
endmodule

// File: rtl/mbx_out_sel.sv
module mbx_out_sel #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              sel_i,
  input  logic [DATA_W-1:0] mbx_i,
  input  logic [DATA_W-1:0] fifo_i,
  output logic [DATA_W-1:0] dout_o
);
  always_comb begin
    if (sel_i) dout_o = mbx_i;
    else       dout_o = fifo_i;
  end
endmodule

// File: rtl/mailbox_pair.sv
module mailbox_pair
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = 18,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              mb1_rst_ni,
  input  logic              mb2_rst_ni,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic              a_mbsel_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [DATA_W-1:0] a_fifo_i,
  output logic [DATA_W-1:0] a_dout_o,
  output logic              a_mb1_full_no,
  output logic              a_mb2_full_no,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  input  logic              b_mbsel_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic [DATA_W-1:0] b_fifo_i,
  output logic [DATA_W-1:0] b_dout_o,
  output logic              b_mb1_full_no,
  output logic              b_mb2_full_no
);
  logic [NUM_CH-1:0] ch_clk_w, ch_clk_r, ch_rst_n, ch_wr, ch_rd;
  logic [NUM_CH-1:0] ch_full_w_n, ch_full_r_n;
  logic [DATA_W-1:0] ch_wdata [NUM_CH];
  logic [DATA_W-1:0] ch_rdata [NUM_CH];

  assign ch_clk_w[CH_A2B] = clk_a_i;
  assign ch_clk_r[CH_A2B] = clk_b_i;
  assign ch_rst_n[CH_A2B] = rst_ni & mb1_rst_ni;
  assign ch_wr[CH_A2B]    = a_wr_i & a_mbsel_i;
  assign ch_rd[CH_A2B]    = b_rd_i & b_mbsel_i;
  assign ch_wdata[CH_A2B] = a_wdata_i;

  assign ch_clk_w[CH_B2A] = clk_b_i;
  assign ch_clk_r[CH_B2A] = clk_a_i;
  assign ch_rst_n[CH_B2A] = rst_ni & mb2_rst_ni;
  assign ch_wr[CH_B2A]    = b_wr_i & b_mbsel_i;
  assign ch_rd[CH_B2A]    = a_rd_i & a_mbsel_i;
  assign ch_wdata[CH_B2A] = b_wdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbx_channel #(
      .DATA_W     (DATA_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
      .clk_w_i  (ch_clk_w[c]),
      .clk_r_i  (ch_clk_r[c]),
      .rst_ni   (ch_rst_n[c]),
      .wr_i     (ch_wr[c]),
      .wdata_i  (ch_wdata[c]),
      .rd_i     (ch_rd[c]),
      .rdata_o  (ch_rdata[c]),
      .full_w_no(ch_full_w_n[c]),
      .full_r_no(ch_full_r_n[c])
    );
  end

  assign a_mb1_full_no = ch_full_w_n[CH_A2B];
  assign b_mb1_full_no = ch_full_r_n[CH_A2B];
  assign b_mb2_full_no = ch_full_w_n[CH_B2A];
  assign a_mb2_full_no = ch_full_r_n[CH_B2A];

  mbx_out_sel #(.DATA_W(DATA_W)) u_sel_a (
    .sel_i (a_mbsel_i),
    .mbx_i (ch_rdata[CH_B2A]),
    .fifo_i(a_fifo_i),
    .dout_o(a_dout_o)
  );

  mbx_out_sel #(.DATA_W(DATA_W)) u_sel_b (
    .sel_i (b_mbsel_i),
    .mbx_i (ch_rdata[CH_A2B]),
    .fifo_i(b_fifo_i),
    .dout_o(b_dout_o)
  );
endmodule

// File: tb/sim_mailbox_pair.sv
module sim_mailbox_pair;
  localparam int CLK_A_PERIOD = 10;
  localparam int CLK_B_PERIOD = 16;
  localparam int W = 18;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_n, mb1_rst_n, mb2_rst_n;
  logic a_wr, a_rd, a_mbsel, b_wr, b_rd, b_mbsel;
  logic [W-1:0] a_wdata, a_fifo, b_wdata, b_fifo, a_dout, b_dout;
  logic a_mb1_n, a_mb2_n, b_mb1_n, b_mb2_n;

  int a_cnt = 0, b_cnt = 0;
  int n_tests = 0, n_fail = 0;
  logic [W-1:0] q1 [$];
  logic [W-1:0] q2 [$];

  always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD/2) clk_b = ~clk_b;
  always @(posedge clk_a) a_cnt <= a_cnt + 1;
  always @(posedge clk_b) b_cnt <= b_cnt + 1;

  mailbox_pair #(.DATA_W(W)) u0 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .mb1_rst_ni(mb1_rst_n), .mb2_rst_ni(mb2_rst_n),
    .a_wr_i(a_wr), .a_rd_i(a_rd), .a_mbsel_i(a_mbsel), .a_wdata_i(a_wdata),
    .a_fifo_i(a_fifo), .a_dout_o(a_dout), .a_mb1_full_no(a_mb1_n), .a_mb2_full_no(a_mb2_n),
    .b_wr_i(b_wr), .b_rd_i(b_rd), .b_mbsel_i(b_mbsel), .b_wdata_i(b_wdata),
    .b_fifo_i(b_fifo), .b_dout_o(b_dout), .b_mb1_full_no(b_mb1_n), .b_mb2_full_no(b_mb2_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic at_a(input int n);
    wait (a_cnt >= n);
    @(negedge clk_a);
  endtask

  task automatic at_b(input int n);
    wait (b_cnt >= n);
    @(negedge clk_b);
  endtask

  // drivers: push expected words into the scoreboard on accepted posts
  task automatic a_post(input logic [W-1:0] d, input bit ok, output int e_b);
    @(posedge clk_a); #2 a_wr = 1'b1; a_mbsel = 1'b1; a_wdata = d;
    @(posedge clk_a); e_b = b_cnt; if (ok) q1.push_back(d);
    #2 a_wr = 1'b0; a_mbsel = 1'b0; a_wdata = ~d;
  endtask

  task automatic b_post(input logic [W-1:0] d, input bit ok, output int e_a);
    @(posedge clk_b); #2 b_wr = 1'b1; b_mbsel = 1'b1; b_wdata = d;
    @(posedge clk_b); e_a = a_cnt; if (ok) q2.push_back(d);
    #2 b_wr = 1'b0; b_mbsel = 1'b0; b_wdata = ~d;
  endtask

  task automatic b_take(input bit sel, output int e_a);
    @(posedge clk_b); #2 b_rd = 1'b1; b_mbsel = sel;
    @(posedge clk_b); e_a = a_cnt;
    #2 b_rd = 1'b0; b_mbsel = 1'b0;
  endtask

  task automatic a_take(input bit sel, output int e_b);
    @(posedge clk_a); #2 a_rd = 1'b1; a_mbsel = sel;
    @(posedge clk_a); e_b = b_cnt;
    #2 a_rd = 1'b0; a_mbsel = 1'b0;
  endtask

  // monitors: compare delivered words against the scoreboard
  always @(negedge clk_b) begin
    if (b_rd && b_mbsel && !b_mb1_n) begin
      if (q1.size() == 0) check("R5 mailbox1 take with no mail expected", 1, 0);
      else check("R3 mailbox1 delivered word", 32'(b_dout), 32'(q1.pop_front()));
    end
  end

  always @(negedge clk_a) begin
    if (a_rd && a_mbsel && !a_mb2_n) begin
      if (q2.size() == 0) check("R5 mailbox2 take with no mail expected", 1, 0);
      else check("R6 mailbox2 delivered word", 32'(a_dout), 32'(q2.pop_front()));
    end
  end

  initial begin
    #(CLK_A_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e;
    rst_n = 0; mb1_rst_n = 1; mb2_rst_n = 1;
    a_wr = 0; a_rd = 0; a_mbsel = 0; b_wr = 0; b_rd = 0; b_mbsel = 0;
    a_wdata = '0; b_wdata = '0; a_fifo = 18'h01234; b_fifo = 18'h02abc;
    #33 rst_n = 1;

    // R8 reset state, R7 mux
    @(negedge clk_a);
    check("R8 reset a_mb1", a_mb1_n, 1); check("R8 reset b_mb1", b_mb1_n, 1);
    check("R8 reset a_mb2", a_mb2_n, 1); check("R8 reset b_mb2", b_mb2_n, 1);
    check("R7 a fifo path", a_dout, 18'h01234); check("R7 b fifo path", b_dout, 18'h02abc);
    a_mbsel = 1; b_mbsel = 1; #1;
    check("R8 reset word a", a_dout, 0); check("R8 reset word b", b_dout, 0);
    a_mbsel = 0; b_mbsel = 0;

    // R1 / R3 post timing
    a_post(18'h0a5a5, 1, e);
    @(negedge clk_a); check("R1 writer flag low", a_mb1_n, 0);
    at_b(e + 1); check("R3 reader flag after first edge", b_mb1_n, 1);
    at_b(e + 2); check("R3 reader flag after second edge", b_mb1_n, 0);

    // R2 / R9 blocked post
    a_post(18'h11111, 0, e);
    @(negedge clk_a); check("R2 writer flag still low", a_mb1_n, 0);
    @(negedge clk_b); b_mbsel = 1; #1;
    check("R9 word held", b_dout, 18'h0a5a5); check("R7 b mailbox path", b_dout, 18'h0a5a5);
    b_mbsel = 0;

    // R4 take timing
    b_take(1, e);
    fork
      begin @(negedge clk_b); check("R4 reader flag high", b_mb1_n, 1); end
      begin
        at_a(e + 1); check("R4 writer flag after first edge", a_mb1_n, 0);
        at_a(e + 2); check("R4 writer flag after second edge", a_mb1_n, 1);
      end
    join

    // R5 ignored strobes
    a_post(18'h3c3c3, 1, e); at_b(e + 2);
    b_take(0, e);
    @(negedge clk_b); check("R5 take with select low", b_mb1_n, 0);
    check("R7 b fifo during take", b_dout, 18'h02abc);
    b_take(1, e); at_a(e + 2); check("R4 writer released", a_mb1_n, 1);
    b_take(1, e); at_a(e + 2);
    check("R5 empty take b flag", b_mb1_n, 1); check("R5 empty take a flag", a_mb1_n, 1);
    @(posedge clk_a); #2 a_wr = 1; a_wdata = 18'h0f0f0;
    @(posedge clk_a); e = b_cnt; #2 a_wr = 0;
    @(negedge clk_a); check("R5 write select low a flag", a_mb1_n, 1);
    at_b(e + 2); check("R5 write select low b flag", b_mb1_n, 1);
    a_post(18'h12345, 1, e); at_b(e + 2);
    check("R5 post after ignored strobes", b_mb1_n, 0);
    b_take(1, e); at_a(e + 2);

    // R6 mailbox 2
    b_post(18'h2468a, 1, e);
    fork
      begin @(negedge clk_b); check("R6 writer flag low", b_mb2_n, 0); end
      begin
        at_a(e + 1); check("R6 reader flag after first edge", a_mb2_n, 1);
        at_a(e + 2); check("R6 reader flag after second edge", a_mb2_n, 0);
      end
    join
    b_post(18'h13579, 0, e);
    a_take(1, e);
    fork
      begin @(negedge clk_a); check("R6 reader flag high", a_mb2_n, 1); end
      begin
        at_b(e + 1); check("R6 writer flag after first edge", b_mb2_n, 0);
        at_b(e + 2); check("R6 writer flag after second edge", b_mb2_n, 1);
      end
    join

    // R8 per-mailbox reset
    b_post(18'h0beef, 1, e); at_a(e + 2);
    a_post(18'h0cafe, 1, e); at_b(e + 2);
    @(negedge clk_a); #1 mb2_rst_n = 0; #2;
    check("R8 mb2 reset a flag", a_mb2_n, 1); check("R8 mb2 reset b flag", b_mb2_n, 1);
    a_mbsel = 1; #1; check("R8 mb2 word cleared", a_dout, 0); a_mbsel = 0;
    check("R8 mb1 untouched a", a_mb1_n, 0); check("R8 mb1 untouched b", b_mb1_n, 0);
    q2.delete();
    @(negedge clk_a); #1 mb2_rst_n = 1;
    a_take(1, e); at_b(e + 2);
    b_take(1, e); at_a(e + 2);
    b_post(18'h31415, 1, e); at_a(e + 2);
    check("R8 post after reset", a_mb2_n, 0);
    a_take(1, e); at_b(e + 2);

    check("R3 R6 all mail delivered", q1.size() + q2.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule